// File: doc/BRIEF.md
# Checked AHB-Lite Slave Front End for an External Memory Controller

This block sits between an AHB-Lite bus and the back end of an external parallel memory controller. Each legal single-beat transfer to the memory region becomes exactly one external access request. The block holds HREADY low until the back end reports completion, and it returns read data on the cycle the transfer completes. A second address region holds one small configuration register per external bank. Software reads and writes these registers over the same bus, and their contents drive the downstream logic continuously.

Before the block forwards a transfer, it checks it. A transfer wider than 32 bits is rejected. So is an access to a bank whose enable bit is clear, and an access to a flash-type bank whose active (not powered down) bit is clear. A rejected transfer gets the standard two-cycle ERROR response and never reaches the back end. Every other transfer completes with OKAY. The only responses the block can return are OKAY and ERROR. It takes no protection input and applies no protection checking.

Top module: `ahbfe_slave`

## Requirements
- R1: A transfer with HSIZE greater than 2, in either region, gets an ERROR response and issues no external request. HSIZE values 0 to 2 are never rejected for their size.
- R2: A memory-region transfer to a bank whose configuration bit 0 (enable) is 0 gets ERROR and issues no external request.
- R3: A memory-region transfer to an enabled bank whose bit 1 (flash type) is 1 and whose bit 2 (active) is 0 gets ERROR. When bit 1 is 0, bit 2 has no effect.
- R4: ERROR is always two cycles. The first cycle has hreadyout=0 with hresp=1, and the second has hreadyout=1 with hresp=1. hresp=0 means OKAY.
- R5: An accepted legal memory transfer raises ext_req for exactly one cycle, the cycle after its address phase. That cycle carries the bank (HADDR[14:13]), the offset (HADDR[12:0]), the direction, the size, and the data-phase HWDATA on ext_wdata. HADDR[15]=0 selects the memory region.
- R6: During a forwarded access, hreadyout stays low until the cycle after ext_done is seen high. In that cycle hreadyout=1 and hresp=0, and for a read hrdata equals the ext_rdata captured with ext_done.
- R7: HADDR[15]=1 selects the configuration region, and HADDR[3:2] picks the bank register. Accesses there complete with zero wait states and OKAY. A write stores HWDATA[7:0]. A read returns the register, zero-extended, in the data phase. cfg_out holds bank k's register at bits [8k+7:8k]. A written value already governs a transfer whose address phase coincides with the write's data phase.
- R8: IDLE and BUSY transfers, and transfers with hsel=0, complete with zero wait states and OKAY. They change no register and issue no request.
- R9: After reset, hreadyout=1, hresp=0, ext_req=0 and every configuration register is 0, so every bank is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 16 | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 for write |
| hsize | input | 3 | Transfer size code |
| hwdata | input | 32 | Write data (data phase) |
| hready | input | 1 | Bus-wide ready, qualifies the address phase |
| hreadyout | output | 1 | This slave's ready |
| hresp | output | 1 | 0 OKAY, 1 ERROR |
| hrdata | output | 32 | Read data |
| ext_req | output | 1 | One-cycle external access request |
| ext_write | output | 1 | Request direction |
| ext_bank | output | 2 | Target bank |
| ext_addr | output | 13 | Offset within the bank |
| ext_size | output | 3 | Request size code |
| ext_wdata | output | 32 | Request write data |
| ext_done | input | 1 | Back end completion strobe |
| ext_rdata | input | 32 | Back end read data, valid with ext_done |
| cfg_out | output | 32 | All bank configuration registers |

## Verification
An accepted address phase has its outcome in the very next cycle. That cycle carries the request pulse, the first ERROR cycle, or the configuration data phase. The ready rise comes one cycle after ext_done. Register contents change on cfg_out one cycle after the write's data phase. The bench keeps a behavioural model that advances on each rising edge from the same inputs the design samples. It compares ready, response, request and read data, plus cfg_out, at every falling edge, so each result is checked in exactly the cycle it is due. Per-transaction checks also count the wait cycles against the back-end latency and count external requests around every rejected or idle transfer.

// File: rtl/ahbfe_pkg.sv
package ahbfe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CFG   = 3'd1,
        ST_ISSUE = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DONE  = 3'd4,
        ST_ERR1  = 3'd5,
        ST_ERR2  = 3'd6
    } fe_state_e;

    typedef enum logic [1:0] {
        RT_MEM = 2'd0,
        RT_CFG = 2'd1,
        RT_ERR = 2'd2
    } fe_route_e;

    localparam int CFG_EN_BIT     = 0;
    localparam int CFG_FLASH_BIT  = 1;
    localparam int CFG_ACTIVE_BIT = 2;
    localparam int MAX_LEGAL_SIZE = 2;

endpackage

// File: rtl/ahbfe_cfg_regs.sv
module ahbfe_cfg_regs #(
    parameter int NUM_BANKS = 4,
    parameter int CFG_W     = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [BANK_W-1:0]          idx,
    input  logic [CFG_W-1:0]           wdata,
    output logic [NUM_BANKS*CFG_W-1:0] cfg_flat
);

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        logic [CFG_W-1:0] reg_d, reg_q;
        logic             hit;

        always_comb begin
            hit   = we && (idx == BANK_W'(k));
            reg_d = hit ? wdata : reg_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) reg_q <= '0;
            else        reg_q <= reg_d;
        end

        assign cfg_flat[k*CFG_W +: CFG_W] = reg_q;

        // R7
        cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && idx == BANK_W'(k)) |=> (cfg_flat[k*CFG_W +: CFG_W] == $past(wdata)));
    end

endmodule

// File: rtl/ahbfe_check.sv
module ahbfe_check
    import ahbfe_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_BANKS = 4,
    parameter int CFG_W     = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [2:0]                 size,
    input  logic [NUM_BANKS*CFG_W-1:0] cfg_eff,
    output fe_route_e                  route
);

    logic [BANK_W-1:0] bank;
    logic [CFG_W-1:0]  bank_cfg;
    logic              too_wide, is_cfg, bank_off, bank_asleep;

    always_comb begin
        bank        = addr[ADDR_W-2 -: BANK_W];
        bank_cfg    = cfg_eff[bank*CFG_W +: CFG_W];
        too_wide    = (size > 3'(MAX_LEGAL_SIZE));
        is_cfg      = addr[ADDR_W-1];
        bank_off    = !bank_cfg[CFG_EN_BIT];
        bank_asleep = bank_cfg[CFG_FLASH_BIT] && !bank_cfg[CFG_ACTIVE_BIT];
        if (too_wide)                    route = RT_ERR;
        else if (is_cfg)                 route = RT_CFG;
        else if (bank_off || bank_asleep) route = RT_ERR;
        else                             route = RT_MEM;
    end

endmodule

// File: rtl/ahbfe_slave.sv
module ahbfe_slave
    import ahbfe_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_BANKS = 4,
    parameter int CFG_W     = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int OFF_W    = ADDR_W - 1 - BANK_W
) (
    input  logic                       hclk,
    input  logic                       hresetn,
    input  logic                       hsel,
    input  logic [ADDR_W-1:0]          haddr,
    input  logic [1:0]                 htrans,
    input  logic                       hwrite,
    input  logic [2:0]                 hsize,
    input  logic [31:0]                hwdata,
    input  logic                       hready,
    output logic                       hreadyout,
    output logic                       hresp,
    output logic [31:0]                hrdata,
    output logic                       ext_req,
    output logic                       ext_write,
    output logic [BANK_W-1:0]          ext_bank,
    output logic [OFF_W-1:0]           ext_addr,
    output logic [2:0]                 ext_size,
    output logic [31:0]                ext_wdata,
    input  logic                       ext_done,
    input  logic [31:0]                ext_rdata,
    output logic [NUM_BANKS*CFG_W-1:0] cfg_out
);

    typedef struct packed {
        fe_state_e         state;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [2:0]        size;
        logic [31:0]       rdata;
    } fe_regs_t;

    fe_regs_t q, d;

    logic                       accept;
    logic                       cfg_we;
    logic [BANK_W-1:0]          cfg_idx;
    logic [NUM_BANKS*CFG_W-1:0] cfg_eff;
    fe_route_e                  route;
    logic                       unused_htrans;

    assign unused_htrans = htrans[0];

    ahbfe_cfg_regs #(.NUM_BANKS(NUM_BANKS), .CFG_W(CFG_W)) u_regs (
        .clk      (hclk),
        .rst_n    (hresetn),
        .we       (cfg_we),
        .idx      (cfg_idx),
        .wdata    (hwdata[CFG_W-1:0]),
        .cfg_flat (cfg_out)
    );

    ahbfe_check #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .CFG_W(CFG_W)) u_check (
        .addr    (haddr),
        .size    (hsize),
        .cfg_eff (cfg_eff),
        .route   (route)
    );

    // register write in its data phase is forwarded to the overlapping check
    always_comb begin
        cfg_we  = (q.state == ST_CFG) && q.write;
        cfg_idx = q.addr[BANK_W+1:2];
        cfg_eff = cfg_out;
        if (cfg_we) cfg_eff[cfg_idx*CFG_W +: CFG_W] = hwdata[CFG_W-1:0];
    end

    always_comb begin
        d      = q;
        accept = hsel && hready && htrans[1];
        case (q.state)
            ST_ISSUE, ST_WAIT: begin
                if (ext_done) begin
                    d.state = ST_DONE;
                    d.rdata = q.write ? '0 : ext_rdata;
                end else begin
                    d.state = ST_WAIT;
                end
            end
            ST_ERR1: d.state = ST_ERR2;
            default: begin
                if (accept) begin
                    d.addr  = haddr;
                    d.write = hwrite;
                    d.size  = hsize;
                    d.rdata = '0;
                    case (route)
                        RT_ERR:  d.state = ST_ERR1;
                        RT_CFG:  d.state = ST_CFG;
                        default: d.state = ST_ISSUE;
                    endcase
                end else begin
                    d.state = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) q <= '0;
        else          q <= d;
    end

    always_comb begin
        hreadyout = (q.state == ST_IDLE) || (q.state == ST_CFG) ||
                    (q.state == ST_DONE) || (q.state == ST_ERR2);
        hresp     = (q.state == ST_ERR1) || (q.state == ST_ERR2);
        hrdata    = '0;
        if (q.state == ST_CFG && !q.write)
            hrdata[CFG_W-1:0] = cfg_out[cfg_idx*CFG_W +: CFG_W];
        else if (q.state == ST_DONE)
            hrdata = q.rdata;
        ext_req   = (q.state == ST_ISSUE);
        ext_write = q.write;
        ext_bank  = q.addr[ADDR_W-2 -: BANK_W];
        ext_addr  = q.addr[OFF_W-1:0];
        ext_size  = q.size;
        ext_wdata = hwdata;
    end

    // R4
    err_second_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (hresp && !hreadyout) |=> (hresp && hreadyout));

    // R4
    err_first_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (hresp && hreadyout) |-> $past(hresp && !hreadyout));

    // R1
    err_no_req_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        hresp |-> !ext_req);

    // R5
    req_pulse_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        ext_req |=> !ext_req);

    // R6
    wait_hold_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (!hreadyout && !hresp && !ext_done) |=> !hreadyout);

    // R6
    done_ready_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (!hreadyout && !hresp && ext_done) |=> (hreadyout && !hresp));

    // R8
    idle_quiet_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (hready && hreadyout && !(hsel && htrans[1])) |=> (hreadyout && !hresp && !ext_req));

endmodule

// File: tb/ahbfe_slave_test.sv
module ahbfe_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16, NUM_BANKS = 4, CFG_W = 8, BANK_W = 2, OFF_W = 13;

    logic hclk = 0, hresetn = 0, hsel = 0, hwrite = 0, hready;
    logic [ADDR_W-1:0] haddr = '0;
    logic [1:0] htrans = 2'b00;
    logic [2:0] hsize = 3'd2;
    logic [31:0] hwdata = '0, hrdata, ext_wdata, ext_rdata = '0;
    logic hreadyout, hresp, ext_req, ext_write, ext_done = 0;
    logic [BANK_W-1:0] ext_bank;
    logic [OFF_W-1:0] ext_addr;
    logic [2:0] ext_size;
    logic [NUM_BANKS*CFG_W-1:0] cfg_out;

    assign hready = hreadyout;
    always #(CLK_PERIOD/2) hclk = ~hclk;

    ahbfe_slave uut (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
        .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata), .ext_req(ext_req),
        .ext_write(ext_write), .ext_bank(ext_bank), .ext_addr(ext_addr),
        .ext_size(ext_size), .ext_wdata(ext_wdata), .ext_done(ext_done),
        .ext_rdata(ext_rdata), .cfg_out(cfg_out)
    );

    int checks = 0, errors = 0, ext_cnt = 0, be_lat = 0, be_cnt = -1;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // back-end model: done arrives be_lat+1 cycles after the request cycle
    always @(negedge hclk) begin
        ext_done = 0;
        if (be_cnt == 0) begin
            ext_done  = 1;
            ext_rdata = 32'hC0DE_0000 | 32'(ext_addr) | (32'(ext_bank) << 13);
            be_cnt    = -1;
        end else if (be_cnt > 0) be_cnt--;
        if (ext_req) begin
            be_cnt = be_lat;
            ext_cnt++;
        end
    end

    // behavioural reference: 0 idle, 1 err first, 2 err second, 3 request, 4 waiting, 5 done, 6 cfg phase
    int m_mode = 0;
    logic [CFG_W-1:0] m_cfg [NUM_BANKS] = '{default: '0};
    logic [ADDR_W-1:0] m_addr = '0;
    logic m_write = 0;
    logic [2:0] m_size = '0;
    logic [31:0] m_rdata = '0, m_wdata_exp = '0;

    function automatic int classify(input logic [ADDR_W-1:0] a, input logic [2:0] s);
        logic [CFG_W-1:0] c;
        if (s > 3'd2) return 1;
        if (a[ADDR_W-1]) return 6;
        c = m_cfg[a[ADDR_W-2 -: BANK_W]];
        if (!c[0]) return 1;
        if (c[1] && !c[2]) return 1;
        return 3;
    endfunction

    always @(posedge hclk) begin
        if (!hresetn) begin
            m_mode = 0;
            for (int i = 0; i < NUM_BANKS; i++) m_cfg[i] = '0;
        end else begin
            if (m_mode == 3) chk(ext_wdata == hwdata, "R5 wdata", ext_wdata, hwdata);
            case (m_mode)
                1: m_mode = 2;
                3, 4: if (ext_done) begin
                        m_mode = 5;
                        m_rdata = m_write ? 32'h0 : ext_rdata;
                      end else m_mode = 4;
                default: begin
                    if (m_mode == 6 && m_write) m_cfg[m_addr[BANK_W+1:2]] = hwdata[CFG_W-1:0];
                    if (hsel && htrans[1]) begin
                        m_addr = haddr; m_write = hwrite; m_size = hsize;
                        m_mode = classify(haddr, hsize);
                    end else m_mode = 0;
                end
            endcase
        end
    end

    always @(negedge hclk) begin
        logic exp_ready, exp_resp, exp_req;
        logic [NUM_BANKS*CFG_W-1:0] exp_cfg;
        exp_ready = (m_mode == 0 || m_mode == 2 || m_mode == 5 || m_mode == 6);
        exp_resp  = (m_mode == 1 || m_mode == 2);
        exp_req   = (m_mode == 3);
        for (int i = 0; i < NUM_BANKS; i++) exp_cfg[i*CFG_W +: CFG_W] = m_cfg[i];
        chk(hreadyout == exp_ready, "R6 ready", 32'(hreadyout), 32'(exp_ready));
        chk(hresp == exp_resp, "R4 resp", 32'(hresp), 32'(exp_resp));
        chk(ext_req == exp_req, "R5 req", 32'(ext_req), 32'(exp_req));
        chk(cfg_out == exp_cfg, "R7 cfg_out", cfg_out, exp_cfg);
        if (exp_req) begin
            chk({ext_bank, ext_addr} == m_addr[ADDR_W-2:0], "R5 addr",
                32'({ext_bank, ext_addr}), 32'(m_addr[ADDR_W-2:0]));
            chk(ext_write == m_write && ext_size == m_size, "R5 ctrl",
                32'({ext_write, ext_size}), 32'({m_write, m_size}));
        end
        if (m_mode == 5 && !m_write) chk(hrdata == m_rdata, "R6 rdata", hrdata, m_rdata);
        if (m_mode == 6 && !m_write)
            chk(hrdata == 32'(m_cfg[m_addr[BANK_W+1:2]]), "R7 rdata", hrdata,
                32'(m_cfg[m_addr[BANK_W+1:2]]));
    end

    task automatic xfer(input logic [ADDR_W-1:0] a, input logic w, input logic [2:0] s,
                        input logic [31:0] wd, output logic resp, output logic [31:0] rd,
                        output int waits);
        @(negedge hclk);
        hsel = 1; haddr = a; htrans = 2'b10; hwrite = w; hsize = s;
        while (!hreadyout) @(negedge hclk);
        @(negedge hclk);
        hsel = 0; htrans = 2'b00; hwdata = wd; waits = 0;
        while (!hreadyout) begin waits++; @(negedge hclk); end
        resp = hresp; rd = hrdata;
    endtask

    function automatic logic [ADDR_W-1:0] mem_a(input int b, input int off);
        return ADDR_W'((b << 13) | off);
    endfunction
    function automatic logic [ADDR_W-1:0] cfg_a(input int b);
        return ADDR_W'(16'h8000 | (b << 2));
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        logic r; logic [31:0] rd; int wt, n0;
        repeat (3) @(negedge hclk);
        chk(hreadyout == 1 && hresp == 0 && ext_req == 0, "R9 outputs",
            32'({hreadyout, hresp, ext_req}), 32'b100);
        chk(cfg_out == '0, "R9 cfg", cfg_out, 0);
        hresetn = 1;

        n0 = ext_cnt;
        xfer(mem_a(0, 5), 0, 3'd2, 0, r, rd, wt);
        chk(r == 1 && ext_cnt == n0, "R2 disabled bank", 32'({r, 8'(ext_cnt - n0)}), 32'h100);
        chk(wt == 1, "R4 error wait", wt, 1);

        xfer(cfg_a(0), 1, 3'd2, 32'hFFFF_FF01, r, rd, wt);
        chk(r == 0 && wt == 0, "R7 cfg write", 32'({r, 8'(wt)}), 0);
        xfer(cfg_a(0), 0, 3'd2, 0, r, rd, wt);
        chk(rd == 32'h01, "R7 cfg read", rd, 32'h01);

        be_lat = 0;
        xfer(mem_a(0, 13'h123), 0, 3'd2, 0, r, rd, wt);
        chk(r == 0 && rd == 32'hC0DE_0123, "R6 read data", rd, 32'hC0DE_0123);
        chk(wt == 2, "R6 waits lat0", wt, 2);

        be_lat = 3; n0 = ext_cnt;
        xfer(mem_a(0, 13'h40), 1, 3'd1, 32'h1234_5678, r, rd, wt);
        chk(r == 0 && wt == 5, "R6 waits lat3", 32'({r, 8'(wt)}), 5);
        chk(ext_cnt == n0 + 1, "R5 single request", ext_cnt - n0, 1);

        be_lat = 1;
        xfer(mem_a(0, 1), 0, 3'd0, 0, r, rd, wt);
        chk(r == 0, "R1 byte size legal", r, 0);

        n0 = ext_cnt;
        xfer(mem_a(0, 8), 0, 3'd3, 0, r, rd, wt);
        chk(r == 1 && ext_cnt == n0, "R1 size 3 memory", 32'({r, 8'(ext_cnt - n0)}), 32'h100);
        xfer(cfg_a(2), 1, 3'd4, 32'h07, r, rd, wt);
        chk(r == 1 && cfg_out[23:16] == 0, "R1 size 4 config", 32'({r, cfg_out[23:16]}), 32'h100);

        xfer(cfg_a(1), 1, 3'd2, 32'h03, r, rd, wt);
        n0 = ext_cnt;
        xfer(mem_a(1, 0), 0, 3'd2, 0, r, rd, wt);
        chk(r == 1 && ext_cnt == n0, "R3 flash asleep", 32'({r, 8'(ext_cnt - n0)}), 32'h100);
        xfer(cfg_a(1), 1, 3'd2, 32'h07, r, rd, wt);
        xfer(mem_a(1, 2), 0, 3'd2, 0, r, rd, wt);
        chk(r == 0 && rd == 32'hC0DE_2002, "R3 flash active", rd, 32'hC0DE_2002);
        xfer(cfg_a(2), 1, 3'd2, 32'h01, r, rd, wt);
        xfer(mem_a(2, 3), 0, 3'd2, 0, r, rd, wt);
        chk(r == 0, "R3 non-flash ignores active bit", r, 0);

        // R8: BUSY, IDLE and deselected transfers
        n0 = ext_cnt;
        @(negedge hclk);
        hsel = 1; haddr = mem_a(0, 4); htrans = 2'b01; hwrite = 0;
        repeat (3) @(negedge hclk);
        chk(hreadyout && !hresp && ext_cnt == n0, "R8 busy", 32'({hreadyout, hresp}), 32'b10);
        htrans = 2'b00; haddr = cfg_a(3); hwrite = 1; hwdata = 32'h01;
        repeat (3) @(negedge hclk);
        hsel = 0; htrans = 2'b10;
        repeat (3) @(negedge hclk);
        htrans = 2'b00;
        repeat (2) @(negedge hclk);
        chk(cfg_out[31:24] == 0 && ext_cnt == n0, "R8 no side effect",
            32'(cfg_out[31:24]), 0);

        // R7 forwarding: cfg write data phase overlaps next address phase
        be_lat = 0; n0 = ext_cnt;
        hsel = 1; haddr = cfg_a(3); htrans = 2'b10; hwrite = 1; hsize = 3'd2;
        @(negedge hclk);
        hwdata = 32'h01; haddr = mem_a(3, 9); hwrite = 0;
        @(negedge hclk);
        hsel = 0; htrans = 2'b00;
        while (!hreadyout) @(negedge hclk);
        chk(hresp == 0 && ext_cnt == n0 + 1, "R7 write forwarded", 32'({hresp, 8'(ext_cnt - n0)}), 1);

        repeat (3) @(negedge hclk);
        finish_run();
    end
endmodule